// File: doc/BRIEF.md
# Global Shutter Exposure Timing Generator

This block produces the per-frame control pulses for a snapshot-shutter pixel array. All timing is counted in system clock cycles. A frame-start trigger begins the sequence. The memory-enable line drops for an overhead window, and inside that window the block issues a precharge pulse and then a sample pulse, which ends the current exposure. When memory-enable returns high, a readout window opens. At the first readout cycle the block raises the pixel reset. The width of that reset sets the next exposure, because exposure runs from the reset's falling edge to the next sample pulse.

The programmed durations are captured only when a trigger is accepted, and each one is clamped to a safe range. The overhead window is stretched until both pulses fit inside it. The readout window is stretched to at least the minimum reset width plus the minimum exposure. The reset width is raised to its programmable minimum. It is cut back when it would leave less than the minimum exposure before the readout window ends, and in that case an error flag is set. An optional second reset pulse, for dual-slope integration, can be placed at a programmable distance after the main reset falls.

Top module: `gst_exposure_gen`

## Requirements
- R1: After reset and between frames, mem_en_o is high. A trigger accepted at clock edge 0 holds mem_en_o low for cycles 0 to OVH-1 (cycle k follows edge k). OVH is cfg_ovh_i raised to at least PRE_W + GAP + SMP_W + 2.
- R2: precharge_o is high for cycles 1 to PRE_W. sample_o rises at cycle 1 + PRE_W + GAP and stays high for SMP_W cycles. GAP is cfg_gap_i, with 0 treated as 1. Both pulses lie inside the low window of R1, and sample_o falls at least one cycle before mem_en_o rises.
- R3: rd_active_o is high for exactly RD cycles, starting at cycle OVH. RD is cfg_rd_len_i raised to at least max(cfg_rst_min_i + MIN_EXP, 1). rd_active_o is never high while mem_en_o is low.
- R4: pix_reset_o rises at the first readout cycle (cycle OVH) and stays high for the granted width W. W equals the requested width cfg_rst_w_i when that request lies within both limits.
- R5: A requested width below cfg_rst_min_i is raised to cfg_rst_min_i, and rst_err_o stays low.
- R6: When the width (after R5) exceeds RD - MIN_EXP, W becomes RD - MIN_EXP and rst_err_o goes high. rst_err_o is updated only at each accepted trigger, so a later frame with a legal width clears it.
- R7: With cfg_ds_en_i = 1 and W + cfg_ds_off_i + DS_W <= RD, ds_reset_o is high for DS_W cycles starting at cycle OVH + W + cfg_ds_off_i. In every other case ds_reset_o stays low for the whole frame.
- R8: A trigger that arrives while a frame is running is ignored. Configuration inputs that change during a frame do not affect it, and new values take effect only at the next accepted trigger.
- R9: While rst_ni is low, every pulse output, rd_active_o and rst_err_o are low, and mem_en_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame-start trigger; accepted only while idle |
| cfg_ovh_i | input | CNT_W | Requested overhead (memory-enable low) length in cycles |
| cfg_gap_i | input | CNT_W | Cycles between the end of precharge and the start of sample |
| cfg_rd_len_i | input | CNT_W | Requested readout window length in cycles |
| cfg_rst_w_i | input | CNT_W | Requested pixel reset width in cycles |
| cfg_rst_min_i | input | CNT_W | Minimum pixel reset width in cycles |
| cfg_ds_en_i | input | 1 | Enables the dual-slope reset pulse |
| cfg_ds_off_i | input | CNT_W | Cycles from the main reset's fall to the dual-slope pulse |
| precharge_o | output | 1 | Precharge pulse |
| sample_o | output | 1 | Sample pulse; ends the exposure |
| mem_en_o | output | 1 | Memory-enable line; low during the overhead window |
| pix_reset_o | output | 1 | Pixel reset; its width sets the next exposure |
| ds_reset_o | output | 1 | Dual-slope reset pulse |
| rd_active_o | output | 1 | Readout window open |
| rst_err_o | output | 1 | The last accepted request was cut back by the minimum-exposure limit |

## Verification
The assertions assume that cfg_* inputs are stable at the accepted trigger edge. They also assume that CNT_W leaves enough room for the clamped sums (MIN_EXP below 2^CNT_W) and that the trigger is synchronous to clk_i. The bench changes configuration and trigger only on falling clock edges and keeps every value well inside 8 bits. Each trigger pulse lasts one cycle, except for the deliberate trigger sent during a running frame. Expected pulse edges come from the clamping formulas in the requirements, and they are compared with the first and last high cycle and the high-cycle count of each output, counted from the trigger edge.

// File: rtl/gst_pkg.sv
`timescale 1ns/1ps
package gst_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OVH  = 2'd1,
    PH_READ = 2'd2
  } gst_phase_e;
endpackage

// File: rtl/gst_cfg_latch.sv
`timescale 1ns/1ps
module gst_cfg_latch #(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 4,
  parameter int SMP_W   = 4,
  parameter int DS_W    = 4,
  parameter int MIN_EXP = 400,
  parameter bit DS_EN   = 1'b1,
  localparam int LW     = CNT_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] ovh_i,
  input  logic [CNT_W-1:0] gap_i,
  input  logic [CNT_W-1:0] rd_i,
  input  logic [CNT_W-1:0] rst_w_i,
  input  logic [CNT_W-1:0] rst_min_i,
  input  logic             ds_en_i,
  input  logic [CNT_W-1:0] ds_off_i,
  output logic [LW-1:0]    ovh_o,
  output logic [LW-1:0]    gap_o,
  output logic [LW-1:0]    rd_o,
  output logic [LW-1:0]    rst_w_o,
  output logic [LW-1:0]    ds_lo_o,
  output logic [LW-1:0]    ds_hi_o,
  output logic             ds_on_o,
  output logic             err_o
);
  localparam logic [LW-1:0] PRE_L  = LW'(PRE_W);
  localparam logic [LW-1:0] SMP_L  = LW'(SMP_W);
  localparam logic [LW-1:0] DSW_L  = LW'(DS_W);
  localparam logic [LW-1:0] MEXP_L = LW'(MIN_EXP);

  logic [LW-1:0] gap_c, ovh_min, ovh_c, rd_min, rd_c, w_req, w_min, w0, w_lim, w_c, ds_lo, ds_hi;
  logic          err_c, ds_fit;

  always_comb begin
    gap_c   = (gap_i == '0) ? LW'(1) : LW'(gap_i);
    ovh_min = PRE_L + gap_c + SMP_L + LW'(2);
    ovh_c   = (LW'(ovh_i) < ovh_min) ? ovh_min : LW'(ovh_i);
    w_min   = LW'(rst_min_i);
    rd_min  = w_min + MEXP_L;
    if (rd_min == '0) rd_min = LW'(1);
    rd_c    = (LW'(rd_i) < rd_min) ? rd_min : LW'(rd_i);
    w_req   = LW'(rst_w_i);
    w0      = (w_req < w_min) ? w_min : w_req;
    w_lim   = rd_c - MEXP_L;
    err_c   = w0 > w_lim;
    w_c     = err_c ? w_lim : w0;
    ds_lo   = w_c + LW'(ds_off_i);
    ds_hi   = ds_lo + DSW_L;
    ds_fit  = DS_EN && ds_en_i && (ds_hi <= rd_c) && (DS_W > 0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovh_o   <= PRE_L + SMP_L + LW'(3);
      gap_o   <= LW'(1);
      rd_o    <= LW'(1);
      rst_w_o <= '0;
      ds_lo_o <= '0;
      ds_hi_o <= '0;
      ds_on_o <= 1'b0;
      err_o   <= 1'b0;
    end else if (load_i) begin
      ovh_o   <= ovh_c;
      gap_o   <= gap_c;
      rd_o    <= rd_c;
      rst_w_o <= w_c;
      ds_lo_o <= ds_lo;
      ds_hi_o <= ds_hi;
      ds_on_o <= ds_fit;
      err_o   <= err_c;
    end
  end

  // R8: latched values move only on an accepted trigger
  a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(rst_w_o) && $stable(rd_o) && $stable(ovh_o) && $stable(err_o)));
endmodule

// File: rtl/gst_phase_ctrl.sv
`timescale 1ns/1ps
module gst_phase_ctrl
  import gst_pkg::*;
#(
  parameter int LW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic [LW-1:0] ovh_i,
  input  logic [LW-1:0] rd_i,
  output gst_phase_e    phase_o,
  output logic [LW-1:0] cnt_o,
  output logic          load_o
);
  gst_phase_e    phase_q;
  logic [LW-1:0] cnt_q;

  assign load_o  = trig_i && (phase_q == PH_IDLE);
  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (trig_i) begin
          phase_q <= PH_OVH;
          cnt_q   <= '0;
        end
        PH_OVH: if (cnt_q == ovh_i - LW'(1)) begin
          phase_q <= PH_READ;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + LW'(1);
        PH_READ: if (cnt_q == rd_i - LW'(1)) begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + LW'(1);
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  // R8: a trigger inside the overhead window does not restart the count
  a_r8_busy_trig_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_OVH && trig_i && cnt_q != ovh_i - LW'(1))
      |=> (phase_q == PH_OVH && cnt_q == $past(cnt_q) + LW'(1)));
  a_r3_read_follows_ovh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_READ && $past(phase_q) != PH_READ) |-> $past(phase_q) == PH_OVH);
endmodule

// File: rtl/gst_pulse_dec.sv
`timescale 1ns/1ps
module gst_pulse_dec
  import gst_pkg::*;
#(
  parameter int LW    = 19,
  parameter int PRE_W = 4,
  parameter int SMP_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  gst_phase_e    phase_i,
  input  logic [LW-1:0] cnt_i,
  input  logic [LW-1:0] gap_i,
  input  logic [LW-1:0] rst_w_i,
  input  logic [LW-1:0] ds_lo_i,
  input  logic [LW-1:0] ds_hi_i,
  input  logic          ds_on_i,
  output logic          precharge_o,
  output logic          sample_o,
  output logic          mem_en_o,
  output logic          pix_reset_o,
  output logic          ds_reset_o,
  output logic          rd_active_o
);
  localparam logic [LW-1:0] PRE_L = LW'(PRE_W);
  localparam logic [LW-1:0] SMP_L = LW'(SMP_W);

  logic in_ovh, in_rd;
  logic [LW-1:0] smp_lo;

  assign in_ovh = (phase_i == PH_OVH);
  assign in_rd  = (phase_i == PH_READ);
  assign smp_lo = LW'(1) + PRE_L + gap_i;

  always_comb begin
    mem_en_o    = !in_ovh;
    rd_active_o = in_rd;
    precharge_o = in_ovh && (cnt_i >= LW'(1)) && (cnt_i <= PRE_L);
    sample_o    = in_ovh && (cnt_i >= smp_lo) && (cnt_i < smp_lo + SMP_L);
    pix_reset_o = in_rd && (cnt_i < rst_w_i);
    ds_reset_o  = in_rd && ds_on_i && (cnt_i >= ds_lo_i) && (cnt_i < ds_hi_i);
  end

  a_r2_pre_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    precharge_o |-> !mem_en_o);
  a_r2_smp_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> !mem_en_o);
  a_r2_smp_ends_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !mem_en_o);
  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(precharge_o && sample_o));
  a_r7_ds_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_reset_o |-> !pix_reset_o);
endmodule

// File: rtl/gst_exposure_gen.sv
`timescale 1ns/1ps
module gst_exposure_gen
  import gst_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 4,
  parameter int SMP_W   = 4,
  parameter int DS_W    = 4,
  parameter int MIN_EXP = 400,
  parameter bit DS_EN   = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic [CNT_W-1:0] cfg_ovh_i,
  input  logic [CNT_W-1:0] cfg_gap_i,
  input  logic [CNT_W-1:0] cfg_rd_len_i,
  input  logic [CNT_W-1:0] cfg_rst_w_i,
  input  logic [CNT_W-1:0] cfg_rst_min_i,
  input  logic             cfg_ds_en_i,
  input  logic [CNT_W-1:0] cfg_ds_off_i,
  output logic             precharge_o,
  output logic             sample_o,
  output logic             mem_en_o,
  output logic             pix_reset_o,
  output logic             ds_reset_o,
  output logic             rd_active_o,
  output logic             rst_err_o
);
  localparam int LW = CNT_W + 3;

  logic [LW-1:0] ovh_q, gap_q, rd_q, rst_w_q, ds_lo_q, ds_hi_q, cnt;
  logic          ds_on_q, load;
  gst_phase_e    phase;

  gst_phase_ctrl #(.LW(LW)) u_phase (
    .clk_i, .rst_ni, .trig_i(frame_start_i), .ovh_i(ovh_q), .rd_i(rd_q),
    .phase_o(phase), .cnt_o(cnt), .load_o(load)
  );

  gst_cfg_latch #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .SMP_W(SMP_W), .DS_W(DS_W),
    .MIN_EXP(MIN_EXP), .DS_EN(DS_EN)
  ) u_cfg (
    .clk_i, .rst_ni, .load_i(load),
    .ovh_i(cfg_ovh_i), .gap_i(cfg_gap_i), .rd_i(cfg_rd_len_i),
    .rst_w_i(cfg_rst_w_i), .rst_min_i(cfg_rst_min_i),
    .ds_en_i(cfg_ds_en_i), .ds_off_i(cfg_ds_off_i),
    .ovh_o(ovh_q), .gap_o(gap_q), .rd_o(rd_q), .rst_w_o(rst_w_q),
    .ds_lo_o(ds_lo_q), .ds_hi_o(ds_hi_q), .ds_on_o(ds_on_q), .err_o(rst_err_o)
  );

  gst_pulse_dec #(.LW(LW), .PRE_W(PRE_W), .SMP_W(SMP_W)) u_dec (
    .clk_i, .rst_ni, .phase_i(phase), .cnt_i(cnt), .gap_i(gap_q),
    .rst_w_i(rst_w_q), .ds_lo_i(ds_lo_q), .ds_hi_i(ds_hi_q), .ds_on_i(ds_on_q),
    .precharge_o, .sample_o, .mem_en_o, .pix_reset_o, .ds_reset_o, .rd_active_o
  );

  a_r3_rd_needs_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_active_o |-> mem_en_o);
  a_r4_reset_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_reset_o |-> rd_active_o);
  a_r4_reset_starts_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pix_reset_o) |-> $rose(rd_active_o));
  a_r9_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (mem_en_o && !pix_reset_o && !rd_active_o && !rst_err_o));
endmodule

// File: tb/gst_exposure_gen_bench.sv
`timescale 1ns/1ps
module gst_exposure_gen_bench;
  localparam int CNT_W = 8, PRE_W = 2, SMP_W = 3, DS_W = 2, MIN_EXP = 6;

  logic clk = 1'b0, rst_n = 1'b0, fs = 1'b0;
  logic [CNT_W-1:0] c_ovh, c_gap, c_rd, c_rw, c_rmin, c_off;
  logic c_dsen;
  logic pre, smp, mem, prst, dsr, rda, err;
  int total = 0, bad = 0;
  bit done = 1'b0;
  int lo[6], hi[6], nh[6];

  always #2.5 clk = ~clk;

  gst_exposure_gen #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SMP_W(SMP_W), .DS_W(DS_W),
                     .MIN_EXP(MIN_EXP), .DS_EN(1'b1)) u_gst_exposure_gen (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs),
    .cfg_ovh_i(c_ovh), .cfg_gap_i(c_gap), .cfg_rd_len_i(c_rd), .cfg_rst_w_i(c_rw),
    .cfg_rst_min_i(c_rmin), .cfg_ds_en_i(c_dsen), .cfg_ds_off_i(c_off),
    .precharge_o(pre), .sample_o(smp), .mem_en_o(mem), .pix_reset_o(prst),
    .ds_reset_o(dsr), .rd_active_o(rda), .rst_err_o(err)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(int ovh, int gap, int rd, int rw, int rmin, bit dsen, int off);
    c_ovh = CNT_W'(ovh); c_gap = CNT_W'(gap); c_rd = CNT_W'(rd);
    c_rw = CNT_W'(rw); c_rmin = CNT_W'(rmin); c_dsen = dsen; c_off = CNT_W'(off);
  endtask

  // one frame; mid >= 0 injects a trigger and a config change at that cycle
  task automatic run_frame(string tag, int ovh, int gap, int rd, int rw, int rmin,
                           bit dsen, int off, int mid);
    int g, oe, re, w0, lim, w, e, n;
    logic [5:0] s;
    g   = (gap == 0) ? 1 : gap;
    oe  = (ovh < PRE_W + g + SMP_W + 2) ? PRE_W + g + SMP_W + 2 : ovh;
    re  = (rmin + MIN_EXP < 1) ? 1 : rmin + MIN_EXP;
    re  = (rd < re) ? re : rd;
    w0  = (rw < rmin) ? rmin : rw;
    lim = re - MIN_EXP;
    e   = (w0 > lim) ? 1 : 0;
    w   = e ? lim : w0;
    n   = oe + re + 3;
    set_cfg(ovh, gap, rd, rw, rmin, dsen, off);
    for (int k = 0; k < 6; k++) begin lo[k] = -1; hi[k] = -1; nh[k] = 0; end
    @(negedge clk) fs = 1'b1;
    @(negedge clk) fs = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (mid >= 0 && i == mid) begin
        fs = 1'b1;
        set_cfg(ovh + 30, gap + 5, rd + 20, rw + 3, rmin, ~dsen, off + 1);
      end
      if (mid >= 0 && i == mid + 1) fs = 1'b0;
      s = {dsr, prst, rda, smp, pre, ~mem};
      for (int k = 0; k < 6; k++)
        if (s[k]) begin
          if (lo[k] < 0) lo[k] = i;
          hi[k] = i; nh[k]++;
        end
    end
    chk({tag, " R1 mem low first"}, lo[0], 0);
    chk({tag, " R1 mem low last"}, hi[0], oe - 1);
    chk({tag, " R1 mem low count"}, nh[0], oe);
    chk({tag, " R2 pre first"}, lo[1], 1);
    chk({tag, " R2 pre count"}, nh[1], PRE_W);
    chk({tag, " R2 smp first"}, lo[2], 1 + PRE_W + g);
    chk({tag, " R2 smp count"}, nh[2], SMP_W);
    chk({tag, " R3 rd first"}, lo[3], oe);
    chk({tag, " R3 rd count"}, nh[3], re);
    chk({tag, " R3 rd last"}, hi[3], oe + re - 1);
    chk({tag, " R4 rst first"}, lo[4], (w > 0) ? oe : -1);
    chk({tag, " R4 rst width"}, nh[4], w);
    chk({tag, " R4 rst last"}, hi[4], (w > 0) ? oe + w - 1 : -1);
    if (dsen && (w + off + DS_W <= re)) begin
      chk({tag, " R7 ds first"}, lo[5], oe + w + off);
      chk({tag, " R7 ds count"}, nh[5], DS_W);
    end else
      chk({tag, " R7 ds absent"}, nh[5], 0);
    chk({tag, " R6 err flag"}, int'(err), e);
    chk({tag, " R1 idle mem high"}, int'(mem), 1);
  endtask

  task automatic t_reset();
    #1;
    chk("R9 mem_en in reset", int'(mem), 1);
    chk("R9 pulses in reset", int'({pre, smp, prst, dsr, rda}), 0);
    chk("R9 err in reset", int'(err), 0);
  endtask

  initial begin
    set_cfg(20, 2, 40, 12, 5, 1'b0, 0);
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_frame("basic R4",         20, 2, 40, 12, 5, 1'b0, 0, -1);
    run_frame("below_min R5",     20, 2, 40,  2, 5, 1'b0, 0, -1);
    run_frame("too_long R6",      20, 2, 40, 38, 5, 1'b0, 0, -1);
    run_frame("err_clears R6",    20, 2, 40, 12, 5, 1'b0, 0, -1);
    run_frame("short_ovh R1 R2",   3, 0, 30,  8, 4, 1'b0, 0, -1);
    run_frame("short_rd R3 R6",   20, 2,  4,  7, 5, 1'b0, 0, -1);
    run_frame("ds_fit R7",        20, 2, 40, 12, 5, 1'b1, 3, -1);
    run_frame("ds_nofit R7",      20, 2, 40, 12, 5, 1'b1, 30, -1);
    run_frame("ds_edge R7",       20, 2, 40, 12, 5, 1'b1, 26, -1);
    run_frame("busy R8",          24, 3, 40, 10, 5, 1'b1, 4, 10);
    run_frame("after_busy R8",    16, 1, 20,  9, 3, 1'b0, 0, -1);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule